// File: doc/BRIEF.md
# Multi-Step Pattern Trigger Sequencer

This block watches a vector of sense inputs and walks through a programmable chain of steps, much like the trigger logic of a logic analyser. Each step carries four match groups. A group compares the unmasked sense bits against a programmed value. When groups collide, the highest-numbered matching group is the only one acted on. Its condition register decides whether a shared counter or timer must also be satisfied, and what to do next: jump, fire, clear a counter or start a timer.

When a fire action executes, a one-cycle trigger pulse is sent toward a cross-trigger network and a sticky interrupt is raised. Software programs the block through a simple write port while the global enable is low. It then raises the enable, and the sequencer evaluates the inputs on every clock from then on. The interrupt is cleared by a register write.

Top module: `seq_trigger`

## Requirements
- R1: After reset, trig_o and irq_o are low, the sequencer is in step 0, and every group is disabled, so no trigger can occur until the block is programmed.
- R2: A group matches when its enable bit (condition bit 7) is set and, for every sense bit whose mask bit is 1, the sense bit equals the value bit. Mask bits at 0 are ignored.
- R3: When several groups of the current step match in the same cycle, only the condition of the highest-numbered matching group takes effect.
- R4: Condition bits [4:3] select the action: 0 jump, 1 fire, 2 clear the selected counter, 3 start the selected counter as a timer. Every executed action also moves to the step in bits [2:0]. A target at or above NUM_STEPS goes to step 0.
- R5: A fire action makes trig_o high for exactly the one cycle after the deciding clock edge, and sets irq_o at that same edge.
- R6: irq_o stays high until a write to address 0x88. A fire in the same cycle as that write leaves irq_o set.
- R7: When condition bit 6 is set, the group also needs the counter chosen by bit 5. A counter in event mode (mode bit 0) counts each cycle in which that group wins. The condition is met on the win at which the incremented count reaches the compare value. At that point the counter clears and the action runs. Otherwise the sequencer stays in its step.
- R8: A counter in timer mode (mode bit 1) starts from 0 on a start action and then increments every clock, saturating at its maximum. A winning group that requires it is satisfied when the count is at least the compare value. The counter is then cleared and stopped.
- R9: Configuration writes are accepted only while en_i is low and are ignored while it is high. The interrupt-clear write is accepted at any time.
- R10: While en_i is low, the sequencer returns to step 0, all counters are cleared and stopped, and no trigger is produced.
- R11: Register map: addresses below 0x80 hold step registers at {step[6:4], group[3:2], kind[1:0]}, where kind 0 is the mask, 1 the value and 2 the condition (bits [7:0]). Address 0x80+c configures counter c: the compare value in data[CNT_W-1:0] and the mode in data[16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global sequencer enable |
| sense_i | input | SENSE_W | Observed signals |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 32 | Register write data |
| trig_o | output | 1 | One-cycle trigger pulse |
| irq_o | output | 1 | Sticky interrupt |

## Verification
The assertions assume that the configuration only changes while en_i is low. They also assume that an event counter's count never passes its compare value while enabled, which follows from the compare value being frozen during enabled operation. The stimulus respects this: every programming burst is issued with the enable low. Writes made while enabled are tried on purpose, and they are expected to have no effect. The sense values are drawn from a narrow range and the masks from a few low bits, so that group collisions, counter satisfaction and timer expiry happen often. The clear and enable toggles land at arbitrary points in a sequence.

// File: rtl/seqtrig_pkg.sv
`timescale 1ns/1ps
package seqtrig_pkg;
  localparam int unsigned GROUPS  = 4;
  localparam int unsigned MAX_CNT = 2;
  localparam logic [7:0] IRQ_CLR_ADDR = 8'h88;

  typedef enum logic [1:0] {
    ACT_GOTO  = 2'd0,
    ACT_FIRE  = 2'd1,
    ACT_CLR   = 2'd2,
    ACT_START = 2'd3
  } act_e;

  typedef struct packed {
    logic       grp_en;
    logic       need_cnt;
    logic       cnt_sel;
    act_e       act;
    logic [2:0] nxt;
  } cond_t;
endpackage

// File: rtl/seqtrig_cfg.sv
`timescale 1ns/1ps
module seqtrig_cfg
  import seqtrig_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 4,
  parameter int unsigned SENSE_W   = 8,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         en_i,
  input  logic                                         wr_en_i,
  input  logic [7:0]                                   wr_addr_i,
  input  logic [31:0]                                  wr_data_i,
  output logic [NUM_STEPS-1:0][GROUPS-1:0][SENSE_W-1:0] mask_o,
  output logic [NUM_STEPS-1:0][GROUPS-1:0][SENSE_W-1:0] val_o,
  output cond_t [NUM_STEPS-1:0][GROUPS-1:0]            cond_o,
  output logic [MAX_CNT-1:0][CNT_W-1:0]                cmp_o,
  output logic [MAX_CNT-1:0]                           mode_o,
  output logic                                         irq_clr_o
);
  logic cfg_we;
  assign cfg_we    = wr_en_i && !en_i;
  assign irq_clr_o = wr_en_i && (wr_addr_i == IRQ_CLR_ADDR);

  logic unused_data;
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      val_o  <= '0;
      cond_o <= '0;
      cmp_o  <= '0;
      mode_o <= '0;
    end else if (cfg_we) begin
      if (!wr_addr_i[7]) begin
        for (int s = 0; s < int'(NUM_STEPS); s++) begin
          for (int g = 0; g < int'(GROUPS); g++) begin
            if (wr_addr_i[6:4] == 3'(s) && wr_addr_i[3:2] == 2'(g)) begin
              case (wr_addr_i[1:0])
                2'd0:    mask_o[s][g] <= wr_data_i[SENSE_W-1:0];
                2'd1:    val_o[s][g]  <= wr_data_i[SENSE_W-1:0];
                2'd2:    cond_o[s][g] <= cond_t'(wr_data_i[7:0]);
                default: ;
              endcase
            end
          end
        end
      end else if (wr_addr_i[6:1] == 6'd0) begin
        cmp_o[wr_addr_i[0]]  <= wr_data_i[CNT_W-1:0];
        mode_o[wr_addr_i[0]] <= wr_data_i[16];
      end
    end
  end

  // R9: programming is frozen while enabled
  p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ($stable(mask_o) && $stable(val_o) && $stable(cond_o)
              && $stable(cmp_o) && $stable(mode_o)));
endmodule

// File: rtl/seqtrig_match.sv
`timescale 1ns/1ps
module seqtrig_match
  import seqtrig_pkg::*;
#(
  parameter int unsigned SENSE_W = 8
) (
  input  logic [SENSE_W-1:0]              sense_i,
  input  logic [GROUPS-1:0][SENSE_W-1:0]  mask_i,
  input  logic [GROUPS-1:0][SENSE_W-1:0]  val_i,
  input  cond_t [GROUPS-1:0]              cond_i,
  output logic                            hit_o,
  output cond_t                           win_o
);
  logic [GROUPS-1:0] grp_hit;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_hit[g] = cond_i[g].grp_en &&
                        (((sense_i ^ val_i[g]) & mask_i[g]) == '0);
  end

  // ascending scan: last hit is the highest-numbered group
  always_comb begin
    hit_o = 1'b0;
    win_o = cond_i[0];
    for (int g = 0; g < int'(GROUPS); g++) begin
      if (grp_hit[g]) begin
        hit_o = 1'b1;
        win_o = cond_i[g];
      end
    end
  end
endmodule

// File: rtl/seqtrig_cnt.sv
`timescale 1ns/1ps
module seqtrig_cnt
  import seqtrig_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned CNT_W   = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [MAX_CNT-1:0][CNT_W-1:0] cmp_i,
  input  logic [MAX_CNT-1:0]           mode_i,
  input  logic                         need_i,
  input  logic                         sel_i,
  input  logic                         go_i,
  input  act_e                         act_i,
  output logic                         sat_o
);
  logic [CNT_W-1:0] cnt_q [MAX_CNT];
  logic             run_q [MAX_CNT];
  logic             sat_c [MAX_CNT];

  for (genvar c = 0; c < MAX_CNT; c++) begin : g_cnt
    if (c < NUM_CNT) begin : g_on
      logic mine;
      logic [CNT_W:0] inc;
      assign mine = (sel_i == 1'(c));
      assign inc  = {1'b0, cnt_q[c]} + 1'b1;
      assign sat_c[c] = mode_i[c] ? (cnt_q[c] >= cmp_i[c])
                                  : (inc >= {1'b0, cmp_i[c]});

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q[c] <= '0;
          run_q[c] <= 1'b0;
        end else if (!en_i) begin
          cnt_q[c] <= '0;
          run_q[c] <= 1'b0;
        end else begin
          if (mode_i[c] && run_q[c] && cnt_q[c] != '1) cnt_q[c] <= inc[CNT_W-1:0];
          if (need_i && mine && !mode_i[c] && !sat_c[c]) cnt_q[c] <= inc[CNT_W-1:0];
          if (go_i && mine && (need_i || act_i == ACT_CLR || act_i == ACT_START)) begin
            cnt_q[c] <= '0;
            run_q[c] <= 1'b0;
          end
          if (go_i && mine && act_i == ACT_START) run_q[c] <= 1'b1;
        end
      end

      p_dis_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q[c] == '0 && !run_q[c]));
      p_evt_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !mode_i[c]) |-> (cnt_q[c] == '0 || cnt_q[c] < cmp_i[c]));
    end else begin : g_off
      logic unused_c;
      assign unused_c = ^{cmp_i[c], mode_i[c]};
      assign cnt_q[c] = '0;
      assign run_q[c] = 1'b0;
      assign sat_c[c] = 1'b0;
    end
  end

  assign sat_o = sat_c[sel_i];
endmodule

// File: rtl/seq_trigger.sv
`timescale 1ns/1ps
module seq_trigger
  import seqtrig_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 4,
  parameter int unsigned SENSE_W   = 8,
  parameter int unsigned NUM_CNT   = 2,
  parameter int unsigned CNT_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_addr_i,
  input  logic [31:0]        wr_data_i,
  output logic               trig_o,
  output logic               irq_o
);
  localparam int unsigned STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;

  logic [NUM_STEPS-1:0][GROUPS-1:0][SENSE_W-1:0] mask_q, val_q;
  cond_t [NUM_STEPS-1:0][GROUPS-1:0]             cond_q;
  logic [MAX_CNT-1:0][CNT_W-1:0]                 cmp_q;
  logic [MAX_CNT-1:0]                            mode_q;
  logic                                          irq_clr;

  logic [STEP_W-1:0] step_q;
  logic              hit, sat, go, fire, nxt_ok;
  cond_t             win;

  seqtrig_cfg #(.NUM_STEPS(NUM_STEPS), .SENSE_W(SENSE_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .en_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mask_o(mask_q), .val_o(val_q), .cond_o(cond_q),
    .cmp_o(cmp_q), .mode_o(mode_q), .irq_clr_o(irq_clr)
  );

  seqtrig_match #(.SENSE_W(SENSE_W)) u_match (
    .sense_i, .mask_i(mask_q[step_q]), .val_i(val_q[step_q]),
    .cond_i(cond_q[step_q]), .hit_o(hit), .win_o(win)
  );

  seqtrig_cnt #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i, .cmp_i(cmp_q), .mode_i(mode_q),
    .need_i(hit && win.need_cnt), .sel_i(win.cnt_sel), .go_i(go),
    .act_i(win.act), .sat_o(sat)
  );

  assign go     = en_i && hit && (!win.need_cnt || sat);
  assign fire   = go && (win.act == ACT_FIRE);
  assign nxt_ok = 32'(win.nxt) < NUM_STEPS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      trig_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      trig_o <= fire;
      if (fire)         irq_o <= 1'b1;
      else if (irq_clr) irq_o <= 1'b0;
      if (!en_i)        step_q <= '0;
      else if (go)      step_q <= nxt_ok ? STEP_W'(win.nxt) : '0;
    end
  end

  p_step_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(step_q) < NUM_STEPS);
  p_trig_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> irq_o);
  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr) |=> irq_o);
  p_dis_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (step_q == '0 && !trig_o));
endmodule

// File: tb/seq_trigger_tb_top.sv
`timescale 1ns/1ps
module seq_trigger_tb_top;
  localparam int NS = 4;
  localparam int NC = 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr_en = 1'b0;
  logic [7:0]  sense = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic trig_o, irq_o;

  always #2.5 clk = ~clk;

  seq_trigger #(.NUM_STEPS(NS), .SENSE_W(8), .NUM_CNT(NC), .CNT_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sense_i(sense),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .trig_o(trig_o), .irq_o(irq_o)
  );

  int checks = 0, errors = 0, npulse = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_mask[NS][4], m_val[NS][4], m_cond[NS][4];
  int m_cmp[NC], m_mode[NC], m_cnt[NC], m_run[NC];
  int m_step;
  bit m_trig, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mask[s, g]) begin m_mask[s][g] = 0; m_val[s][g] = 0; m_cond[s][g] = 0; end
      foreach (m_cmp[c]) begin m_cmp[c] = 0; m_mode[c] = 0; m_cnt[c] = 0; m_run[c] = 0; end
      m_step = 0; m_trig = 0; m_irq = 0;
    end else begin
      automatic int old[NC];
      automatic bit fire = 0;
      automatic bit clr = wr_en && (wr_addr == 8'h88);
      automatic int a = int'(wr_addr), d = int'(wr_data);
      foreach (old[c]) old[c] = m_cnt[c];
      if (wr_en && !en) begin
        if (a < 128) begin
          automatic int s = (a >> 4) & 7, g = (a >> 2) & 3, k = a & 3;
          if (s < NS) begin
            if (k == 0) m_mask[s][g] = d & 255;
            if (k == 1) m_val[s][g]  = d & 255;
            if (k == 2) m_cond[s][g] = d & 255;
          end
        end else if (a == 128 || a == 129) begin
          m_cmp[a & 1]  = d & 255;
          m_mode[a & 1] = (d >> 16) & 1;
        end
      end
      if (!en) begin
        m_step = 0;
        foreach (m_cnt[c]) begin m_cnt[c] = 0; m_run[c] = 0; end
      end else begin
        automatic int win = -1;
        foreach (m_cnt[c]) if (m_mode[c] != 0 && m_run[c] != 0 && old[c] < 255) m_cnt[c] = old[c] + 1;
        for (int g = 3; g >= 0; g--)
          if (win < 0 && ((m_cond[m_step][g] >> 7) & 1) == 1 &&
              ((int'(sense) ^ m_val[m_step][g]) & m_mask[m_step][g]) == 0) win = g;
        if (win >= 0) begin
          automatic int cd = m_cond[m_step][win];
          automatic int need = (cd >> 6) & 1, sel = (cd >> 5) & 1, act = (cd >> 3) & 3, nx = cd & 7;
          automatic bit ok = 1;
          if (need == 1) begin
            if (sel >= NC) ok = 0;
            else if (m_mode[sel] != 0) ok = old[sel] >= m_cmp[sel];
            else begin
              ok = (old[sel] + 1) >= m_cmp[sel];
              if (!ok) m_cnt[sel] = old[sel] + 1;
            end
          end
          if (ok) begin
            if (need == 1) begin m_cnt[sel] = 0; m_run[sel] = 0; end
            if (act == 1) fire = 1;
            if (act == 2 && sel < NC) begin m_cnt[sel] = 0; m_run[sel] = 0; end
            if (act == 3 && sel < NC) begin m_cnt[sel] = 0; m_run[sel] = 1; end
            m_step = (nx < NS) ? nx : 0;
          end
        end
      end
      m_trig = fire;
      if (fire) m_irq = 1;
      else if (clr) m_irq = 0;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (trig_o !== m_trig || irq_o !== m_irq) begin
        errors++;
        $display("FAIL %s model: trig=%0b exp %0b irq=%0b exp %0b", cur_req, trig_o, m_trig, irq_o, m_irq);
      end
      if (trig_o === 1'b1) npulse++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 8'(a); wr_data = 32'(d);
    cyc(1);
    wr_en = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sa(input int s, input int g, input int k);
    return (s << 4) | (g << 2) | k;
  endfunction

  function automatic int mk(input int need, input int sel, input int act, input int nx);
    return 128 | (need << 6) | (sel << 5) | (act << 3) | nx;
  endfunction

  task automatic clear_cfg();
    en = 0;
    for (int s = 0; s < NS; s++)
      for (int g = 0; g < 4; g++)
        for (int k = 0; k < 3; k++) wr(sa(s, g, k), 0);
    wr(128, 0); wr(129, 0);
  endtask

  task automatic seq(input int v);
    sense = 8'(v); cyc(1);
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(trig_o == 0 && irq_o == 0, "R1 reset outputs", int'({trig_o, irq_o}), 0);
    en = 1; sense = 8'hFF; cyc(4);
    chk(npulse == 0, "R1 no trigger when unprogrammed", npulse, 0);

    cur_req = "R2";
    clear_cfg();
    wr(sa(0, 0, 0), 'hFF); wr(sa(0, 0, 1), 'h11); wr(sa(0, 0, 2), mk(0, 0, 0, 1));
    wr(sa(1, 0, 0), 'hF0); wr(sa(1, 0, 1), 'h20); wr(sa(1, 0, 2), mk(0, 0, 1, 0));
    sense = 0; en = 1; p = npulse;
    seq('h00); seq('h11); seq('h25); seq('h25); seq('h11); seq('h2A); seq(0); seq(0);
    chk(npulse - p == 2, "R2 masked two-step sequence", npulse - p, 2);
    chk(irq_o == 1, "R5 fire sets irq", irq_o, 1);

    cur_req = "R6";
    wr(8'h88, 0); cyc(1);
    chk(irq_o == 0, "R6 irq cleared by write while enabled", irq_o, 0);

    cur_req = "R3";
    clear_cfg();
    wr(sa(0, 1, 0), 'h0F); wr(sa(0, 1, 1), 'h01); wr(sa(0, 1, 2), mk(0, 0, 0, 2));
    wr(sa(0, 2, 0), 'h0F); wr(sa(0, 2, 1), 'h01); wr(sa(0, 2, 2), mk(0, 0, 1, 0));
    sense = 0; en = 1; p = npulse;
    seq('h01); seq(0); seq(0);
    chk(npulse - p == 1, "R3 higher group wins", npulse - p, 1);

    cur_req = "R7";
    clear_cfg();
    wr(128, 3);
    wr(sa(0, 3, 0), 'hFF); wr(sa(0, 3, 1), 'h5A); wr(sa(0, 3, 2), mk(1, 0, 1, 0));
    sense = 0; en = 1; p = npulse;
    seq('h5A); seq('h5A); seq(0); seq(0);
    chk(npulse - p == 0, "R7 no fire before count reached", npulse - p, 0);
    seq('h5A); seq(0);
    chk(npulse - p == 1, "R7 fire on third match", npulse - p, 1);

    cur_req = "R10";
    p = npulse;
    seq('h5A); seq('h5A);
    en = 0; seq(0); en = 1;
    seq('h5A); seq('h5A); seq(0);
    chk(npulse - p == 0, "R10 disable clears counter", npulse - p, 0);
    seq('h5A); seq(0);
    chk(npulse - p == 1, "R10 count restarts after enable", npulse - p, 1);

    cur_req = "R8";
    clear_cfg();
    wr(129, 4 | (1 << 16));
    wr(sa(0, 0, 2), mk(0, 1, 3, 1));
    wr(sa(1, 0, 2), mk(1, 1, 1, 0));
    sense = 0; en = 1; p = npulse;
    cyc(20);
    chk(npulse - p == 3, "R8 timer fires every six cycles", npulse - p, 3);

    cur_req = "R9";
    clear_cfg();
    wr(8'h88, 0);
    en = 1; p = npulse;
    wr(sa(0, 0, 2), mk(0, 0, 1, 0));
    cyc(6);
    chk(npulse - p == 0 && irq_o == 0, "R9 write while enabled ignored", npulse - p, 0);
    en = 0; cyc(1);

    cur_req = "R4";
    clear_cfg();
    wr(sa(0, 0, 0), 'hFF); wr(sa(0, 0, 1), 'h01); wr(sa(0, 0, 2), mk(0, 0, 0, 6));
    wr(sa(0, 1, 0), 'hFF); wr(sa(0, 1, 1), 'h02); wr(sa(0, 1, 2), mk(0, 0, 1, 0));
    sense = 0; en = 1; p = npulse;
    seq('h01); seq('h02); seq(0);
    chk(npulse - p == 1, "R4 out-of-range target returns to step 0", npulse - p, 1);

    cur_req = "R11";
    for (int blk = 0; blk < 10; blk++) begin
      en = 0;
      for (int i = 0; i < 40; i++) begin
        int r = int'($urandom_range(0, 9));
        if (r < 8) begin
          int k = int'($urandom_range(0, 2));
          int d = (k == 0) ? int'($urandom & 32'h0F) :
                  (k == 1) ? int'($urandom & 32'hFF) : int'($urandom & 32'hFF);
          wr(sa(int'($urandom_range(0, NS - 1)), int'($urandom_range(0, 3)), k), d);
        end else begin
          wr(128 + int'($urandom_range(0, 1)), int'($urandom_range(0, 5)) | (int'($urandom_range(0, 1)) << 16));
        end
      end
      en = 1;
      for (int i = 0; i < 300; i++) begin
        int r = int'($urandom_range(0, 49));
        sense = 8'($urandom & 32'h0F);
        if (r == 0) wr(8'h88, 0);
        else if (r == 1) wr(sa(0, int'($urandom_range(0, 3)), 2), 255);
        else cyc(1);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule